// File: doc/BRIEF.md
# Same-Frequency Clock-Crossing Word Buffer

This block carries one data word per cycle from a write clock domain into a read clock domain. Both clocks run at the same nominal rate, but their phase relation is unknown and may wander slowly. Four flip-flop slots hold the words in flight. A write pointer steps through the slots on every write clock once the write reset is released. A start flag raised by the writer crosses into the read domain through a two-stage synchronizer. When the flag arrives, the reader begins draining the slots in the same order, two to three slots behind the writer.

The reader also watches the distance between the two pointers. A gray-coded copy of the write pointer crosses through its own two-stage synchronizer. The reader adds the two cycles of synchronizer lag back to that copy and subtracts its own pointer. The result is an estimate of how many slots separate the pointers. If that estimate wraps to zero, the two sides have slipped into each other (a spacing of 0 or 4), and a sticky error flag is raised.

Neither edge has back-pressure. The writer takes `wr_data` on every write clock while `wrst` is low. The reader presents a new `rd_data` word on every read clock while `rd_valid` is high, and the consumer must take it; there is no ready input. Both resets are meant to be asserted together. Asserting the write reset alone while the reader is active is not supported.

Top module: `meso_xbuf`

## Requirements
- R1: While `rrst` is high, `rd_valid` and `slip_err` are both low. Asserting the read reset clears a raised `slip_err`.
- R2: After the write reset is released, `rd_valid` stays low for at least the first two read-clock cycles, because the start flag passes two synchronizer flops. It rises within six read cycles.
- R3: The first word presented with `rd_valid` high is the word on `wr_data` at the first write-clock edge after `wrst` falls. Each later word is the next word written, with no gap and no repeat. Both pointers are 2 bits, advance by one per word, and wrap modulo 4.
- R4: Once `rd_valid` is high, it stays high on every read cycle until the read reset. The reader never stalls.
- R5: If the read clock phase is pushed later by less than the room left before the next write edge, the spacing stays at three slots. The data stream continues unbroken and `slip_err` stays low.
- R6: If the write clock phase is pushed later until the spacing falls to one slot, the data stream continues unbroken and `slip_err` stays low.
- R7: The spacing estimate is the synchronized write pointer plus two minus the read pointer, modulo 4. At the nominal start-up spacing of three, no error is flagged. When the reader falls a full slot further behind, so the estimate reaches 4 (reads as 0), `slip_err` goes high.
- R8: When the writer falls behind until the spacing reaches 0, `slip_err` goes high.
- R9: Once high, `slip_err` stays high until the read reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| wrst | input | 1 | Active-high reset, synchronous to `wclk` |
| wr_data | input | DATA_W | Word captured on every `wclk` edge while out of reset |
| rclk | input | 1 | Read-domain clock, same nominal frequency as `wclk` |
| rrst | input | 1 | Active-high reset, synchronous to `rclk` |
| rd_data | output | DATA_W | Registered word leaving the buffer |
| rd_valid | output | 1 | High on every read cycle that carries a word |
| slip_err | output | 1 | Sticky flag: pointer spacing reached 0 or 4 |

## Verification
The bench resets the block under several phase relations between the two clocks and then stretches one clock by a chosen amount, so the pointer spacing lands on 1, 3, 4 or 0. A design that reads before the start flag is fully synchronized would raise `rd_valid` in the first two cycles. A design with an off-by-one start slot would emit a first word other than the first one written. A mis-set lag constant in the spacing estimate would either flag a slip at the legal spacings of one and three, or stay silent at spacings of four and zero. A non-sticky flag, or a reset that fails to clear it, is caught by checks taken after the slip and after the final reset.

// File: rtl/meso_xbuf_pkg.sv
package meso_xbuf_pkg;
  localparam int PTR_W    = 2;
  localparam int DEPTH    = 1 << PTR_W;
  localparam int SYNC_LAG = 2;

  typedef logic [PTR_W-1:0] ptr_t;

  function automatic ptr_t to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/meso_xbuf_sync.sv
module meso_xbuf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/meso_xbuf_wr.sv
module meso_xbuf_wr
  import meso_xbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         wclk,
  input  logic                         wrst,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0] slots,
  output ptr_t                         wgray,
  output logic                         wstart
);
  ptr_t wptr;
  ptr_t wptr_nxt;

  assign wptr_nxt = wptr + ptr_t'(1);

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wptr   <= '0;
      wgray  <= '0;
      wstart <= 1'b0;
    end else begin
      wptr   <= wptr_nxt;
      wgray  <= to_gray(wptr_nxt);
      wstart <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge wclk) begin
      if (!wrst && wptr == ptr_t'(i)) q <= wr_data;
    end
    assign slots[i] = q;
  end

  // R3
  wptr_step_chk: assert property (@(posedge wclk) disable iff (wrst)
    1'b1 |=> wptr == ptr_t'($past(wptr) + ptr_t'(1)));

  // R7
  gray_step_chk: assert property (@(posedge wclk) disable iff (wrst)
    1'b1 |=> $countones(wgray ^ $past(wgray)) == 1);
endmodule

// File: rtl/meso_xbuf_rd.sv
module meso_xbuf_rd
  import meso_xbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         rclk,
  input  logic                         rrst,
  input  logic [DEPTH-1:0][DATA_W-1:0] slots,
  input  logic                         start_s,
  input  ptr_t                         wgray_s,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rd_valid,
  output logic                         slip_err
);
  ptr_t rptr;
  ptr_t wptr_s;
  ptr_t est_gap;

  assign wptr_s  = from_gray(wgray_s);
  assign est_gap = wptr_s + ptr_t'(SYNC_LAG) - rptr;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rptr     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      slip_err <= 1'b0;
    end else begin
      if (start_s) begin
        rd_data  <= slots[rptr];
        rptr     <= rptr + ptr_t'(1);
        rd_valid <= 1'b1;
      end
      if (rd_valid && est_gap == '0) slip_err <= 1'b1;
    end
  end

  // R4
  valid_hold_chk: assert property (@(posedge rclk) disable iff (rrst)
    rd_valid |=> rd_valid);

  // R9
  slip_hold_chk: assert property (@(posedge rclk) disable iff (rrst)
    slip_err |=> slip_err);

  // R2
  valid_start_chk: assert property (@(posedge rclk) disable iff (rrst)
    $rose(rd_valid) |-> start_s);

  // R3
  rptr_step_chk: assert property (@(posedge rclk) disable iff (rrst)
    rd_valid |=> rptr == ptr_t'($past(rptr) + ptr_t'(1)));
endmodule

// File: rtl/meso_xbuf.sv
module meso_xbuf
  import meso_xbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rclk,
  input  logic              rrst,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              slip_err
);
  logic [DEPTH-1:0][DATA_W-1:0] slots;
  ptr_t                         wgray;
  ptr_t                         wgray_s;
  logic                         wstart;
  logic                         start_s;

  meso_xbuf_wr #(.DATA_W(DATA_W)) u_wr (
    .wclk    (wclk),
    .wrst    (wrst),
    .wr_data (wr_data),
    .slots   (slots),
    .wgray   (wgray),
    .wstart  (wstart)
  );

  meso_xbuf_sync #(.W(1)) u_start_sync (
    .clk (rclk),
    .rst (rrst),
    .d   (wstart),
    .q   (start_s)
  );

  meso_xbuf_sync #(.W(PTR_W)) u_ptr_sync (
    .clk (rclk),
    .rst (rrst),
    .d   (wgray),
    .q   (wgray_s)
  );

  meso_xbuf_rd #(.DATA_W(DATA_W)) u_rd (
    .rclk     (rclk),
    .rrst     (rrst),
    .slots    (slots),
    .start_s  (start_s),
    .wgray_s  (wgray_s),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .slip_err (slip_err)
  );
endmodule

// File: tb/tb_meso_xbuf.sv
`timescale 1ns/1ps
module tb_meso_xbuf;
  localparam int DW   = 16;
  localparam int NVEC = 6;
  // columns: read-clock stretch (ns), write-clock stretch (ns), slip expected, first word
  localparam int VEC [NVEC][4] = '{
    '{0,  0,  0, 16'h1000},
    '{5,  0,  0, 16'h2200},
    '{0,  5,  0, 16'h3ff0},
    '{0,  15, 0, 16'hfffa},
    '{10, 0,  1, 16'h0100},
    '{0,  35, 1, 16'h7ffe}
  };

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          wrst = 1'b1;
  logic          rrst = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          slip_err;

  int            wstall = 0;
  int            rstall = 3;
  int            total = 0;
  int            fails = 0;
  logic [DW-1:0] seed = '0;
  logic [DW-1:0] prev = '0;
  bit            data_chk = 1'b0;
  bit            seen = 1'b0;
  string         cont_tag = "R3";

  meso_xbuf #(.DATA_W(DW)) dut (
    .wclk(wclk), .wrst(wrst), .wr_data(wr_data),
    .rclk(rclk), .rrst(rrst),
    .rd_data(rd_data), .rd_valid(rd_valid), .slip_err(slip_err)
  );

  always begin
    if (wstall > 0) begin #(wstall); wstall = 0; end
    wclk = 1'b0; #5; wclk = 1'b1; #5;
  end

  always begin
    if (rstall > 0) begin #(rstall); rstall = 0; end
    rclk = 1'b0; #5; rclk = 1'b1; #5;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // write data source: seed during reset, then one step per write cycle
  initial forever begin
    @(negedge wclk);
    if (wrst) wr_data = seed;
    else      wr_data = wr_data + 16'd1;
  end

  // read monitor
  initial forever begin
    @(negedge rclk);
    if (rrst) seen = 1'b0;
    else begin
      if (seen) chk(rd_valid == 1'b1, "R4 valid dropped", rd_valid, 1);
      if (rd_valid) begin
        if (!seen) chk(rd_data == seed, "R3 first word", rd_data, seed);
        else if (data_chk)
          chk(rd_data == DW'(prev + 16'd1), cont_tag, rd_data, DW'(prev + 16'd1));
        prev = rd_data;
        seen = 1'b1;
      end
    end
  end

  initial begin
    #100000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int v = 0; v < NVEC; v++) begin
      data_chk = 1'b0;
      wrst = 1'b1;
      rrst = 1'b1;
      seed = DW'(VEC[v][3]);
      repeat (4) @(negedge wclk);
      #2;
      chk(rd_valid == 1'b0, "R1 valid in reset", rd_valid, 0);
      chk(slip_err == 1'b0, "R1 slip in reset", slip_err, 0);
      @(negedge rclk); #1 rrst = 1'b0;
      @(negedge wclk); #1 wrst = 1'b0;
      for (int k = 0; k < 2; k++) begin
        @(negedge rclk);
        chk(rd_valid == 1'b0, "R2 early valid", rd_valid, 0);
      end
      for (int k = 0; k < 4 && !rd_valid; k++) @(negedge rclk);
      chk(rd_valid == 1'b1, "R2 start latency", rd_valid, 1);
      cont_tag = (VEC[v][0] != 0) ? "R5 stream" : ((VEC[v][1] != 0) ? "R6 stream" : "R3 stream");
      data_chk = 1'b1;
      repeat (20) @(negedge wclk);
      #2;
      chk(slip_err == 1'b0, "R7 nominal spacing", slip_err, 0);
      if (VEC[v][2] != 0) data_chk = 1'b0;
      rstall = VEC[v][0];
      wstall = VEC[v][1];
      repeat (30) @(negedge wclk);
      #1;
      if (VEC[v][2] != 0)
        chk(slip_err == 1'b1, (VEC[v][0] != 0) ? "R7 spacing four" : "R8 spacing zero", slip_err, 1);
      else
        chk(slip_err == 1'b0, (VEC[v][0] != 0) ? "R5 no slip" : "R6 no slip", slip_err, 0);
      if (VEC[v][2] != 0) begin
        repeat (10) @(negedge wclk);
        chk(slip_err == 1'b1, "R9 sticky", slip_err, 1);
      end
    end
    // directed: reset after a slip clears the flag
    data_chk = 1'b0;
    wrst = 1'b1;
    rrst = 1'b1;
    repeat (4) @(negedge wclk);
    #2;
    chk(slip_err == 1'b0, "R1 slip cleared", slip_err, 0);
    chk(rd_valid == 1'b0, "R1 valid cleared", rd_valid, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule